// File: doc/BRIEF.md
# Crypto Stream Request Protocol Checker

This block observes the request side of an AXI4-Stream link that feeds an authenticated-encryption engine. It does not drive the link. It reads the valid/ready handshake and the sideband that qualifies each beat: the beat kind, an AES-request flag, and block and packet framing marks. From these it tracks four things:

- whether a block is open;
- whether a packet is open;
- whether a key has been loaded;
- how many data beats and AES blocks the current packet has carried.

Each accepted beat is checked against a fixed set of ordering rules. Each rule has its own error code.

The first violation is captured and held until reset. `err_status` pulses for one cycle. The error code appears on `err_code` in that same cycle and stays there. `err_irq` rises and stays high. The block never recovers by itself, so the surrounding system must reset it to clear a captured error. Two parameters set the limits: `MAX_PKT_BEATS` is the packet length limit in beats, and `CTR_LIMIT` is the largest number of AES data beats one packet may carry.

Top module: `crypto_req_checker`

## Requirements
- R1: Reset sets `err_status`, `err_irq` and `err_code` to 0. A legal sequence raises none of them. A legal sequence is: a key beat that opens a block, an IV beat that opens a packet, data beats, then a final data beat that ends the packet and the block.
- R2: A beat with `req_aes`=1 while `cfg_aes_en`=0 raises code 0x13.
- R3: A beat with `req_eob`=1 and `req_sob`=0 while no block is open raises code 0x03. `req_eob` closes the block after its beat; `req_sob` opens a block on its beat.
- R4: A beat with `req_sob`=0 while no block is open raises code 0x02.
- R5: A data beat (`req_kind`=0) with no key loaded raises code 0x17. A key beat (`req_kind`=1) loads the key. A security-association update beat (`req_kind`=3) discards it.
- R6: Code 0x19 is raised in either of two cases. The first is a beat with `req_sop`=1 whose kind is not IV (`req_kind`=2). The second is a data beat with `req_sop`=0 while no packet is open. An IV beat with `req_sop`=1 opens a packet, and `req_eop`=1 closes it.
- R7: The data beat that brings a packet's data count to `MAX_PKT_BEATS` raises code 0x1B when it has `req_eop`=0. The same beat with `req_eop`=1 is legal.
- R8: In an open packet, an AES data beat that arrives after `CTR_LIMIT` AES data beats raises code 0x07. The count returns to zero at every `req_sop`.
- R9: When one beat breaks several rules, a single code is reported. The order of precedence, highest first, is 0x13, 0x03, 0x02, 0x17, 0x19, 0x07, 0x1B.
- R10: Only the first error is captured. `err_status` is high in exactly the cycle after the offending beat. `err_code` and `err_irq`=1 hold until reset. Later violations change nothing.
- R11: A beat is accepted only when `req_valid` and `req_ready` are both high. Any other cycle has no effect on the checks or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_aes_en | input | 1 | AES is permitted when 1 |
| req_valid | input | 1 | Link valid |
| req_ready | input | 1 | Link ready |
| req_kind | input | 2 | Beat kind: 0 data, 1 key, 2 IV, 3 SA update |
| req_aes | input | 1 | Beat requests AES processing |
| req_sob | input | 1 | Beat opens a block |
| req_eob | input | 1 | Beat closes the block |
| req_sop | input | 1 | Beat opens a packet |
| req_eop | input | 1 | Beat closes the packet |
| err_status | output | 1 | One-cycle strobe for the captured error |
| err_code | output | 8 | Captured error code, held until reset |
| err_irq | output | 1 | Level interrupt, held until reset |

## Verification
The AES block-limit and length-limit errors are the hardest conditions to reach. Each one needs a long, otherwise legal run of data beats inside an open packet, and any earlier slip in the framing would capture a different code first. The bench therefore uses small limits (12 beats and 5 AES blocks). It builds a complete key/IV preamble and then walks each packet to exactly one beat short of the limit. It also walks a packet across a second `req_sop` to show that the AES count starts again from zero. A behavioural model compares all three outputs on every clock.

// File: rtl/crypto_req_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the crypto request checker: beat kinds, error codes
// and the precedence order of the rules. Assumes codes fit in 8 bits.
package crypto_req_pkg;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_KEY  = 2'd1,
        KIND_IV   = 2'd2,
        KIND_SA   = 2'd3
    } beat_kind_e;

    localparam int unsigned CODE_W   = 8;
    localparam int unsigned NUM_VIOL = 7;

    // Rank 0 is the highest precedence.
    localparam int unsigned RANK_AES_OFF    = 0;
    localparam int unsigned RANK_EOB_ORPHAN = 1;
    localparam int unsigned RANK_NO_SOB     = 2;
    localparam int unsigned RANK_NO_KEY     = 3;
    localparam int unsigned RANK_NO_IV      = 4;
    localparam int unsigned RANK_CTR_WRAP   = 5;
    localparam int unsigned RANK_NO_EOP     = 6;

    localparam logic [CODE_W-1:0] CODE_BY_RANK [NUM_VIOL] = '{
        8'h13, 8'h03, 8'h02, 8'h17, 8'h19, 8'h07, 8'h1B
    };

endpackage

// File: rtl/crypto_req_block_track.sv
`timescale 1ns/1ps
// Block framing tracker. Holds whether a block is open and flags beats that
// arrive outside a block or close a block that was never opened.
// Assumes beat_fire is already the link handshake.
module crypto_req_block_track (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_fire,
    input  logic sob,
    input  logic eob,
    output logic blk_open,
    output logic viol_no_sob,
    output logic viol_eob_orphan
);

    // Raw rule flags; precedence is resolved downstream.
    always_comb begin
        viol_no_sob     = beat_fire && !sob && !blk_open;
        viol_eob_orphan = beat_fire && eob && !sob && !blk_open;
    end

    // Block open state: end-of-block wins over start-of-block on one beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_open <= 1'b0;
        end else if (beat_fire) begin
            if (eob) begin
                blk_open <= 1'b0;
            end else if (sob) begin
                blk_open <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/crypto_req_packet_track.sv
`timescale 1ns/1ps
// Packet tracker. Opens a packet on an IV beat marked start-of-packet and
// counts data beats and AES data beats per packet. Flags a missing IV, a
// run past the length limit and an AES count past the block limit.
// Assumes counters may saturate once an error is already captured.
module crypto_req_packet_track
    import crypto_req_pkg::*;
#(
    parameter int unsigned MAX_PKT_BEATS = 4096,
    parameter int unsigned CTR_W         = 32,
    parameter logic [CTR_W-1:0] CTR_LIMIT = {{(CTR_W-1){1'b1}}, 1'b0}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_fire,
    input  beat_kind_e kind,
    input  logic       aes,
    input  logic       sop,
    input  logic       eop,
    output logic       pkt_open,
    output logic       viol_no_iv,
    output logic       viol_ctr_wrap,
    output logic       viol_no_eop
);

    localparam int unsigned LEN_W = $clog2(MAX_PKT_BEATS + 1);
    localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(MAX_PKT_BEATS - 1);

    logic [LEN_W-1:0] len_cnt;
    logic [CTR_W-1:0] aes_cnt;
    logic             is_data;
    logic             in_pkt_data;

    // Classify the current beat.
    always_comb begin
        is_data     = (kind == KIND_DATA);
        in_pkt_data = beat_fire && is_data && pkt_open && !sop;
    end

    // Raw packet rule flags.
    always_comb begin
        viol_no_iv    = beat_fire && ((sop && kind != KIND_IV) ||
                                      (is_data && !sop && !pkt_open));
        viol_ctr_wrap = in_pkt_data && aes && (aes_cnt >= CTR_LIMIT);
        viol_no_eop   = in_pkt_data && !eop && (len_cnt >= LEN_LAST);
    end

    // Packet state and per-packet counters, cleared at each start-of-packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_open <= 1'b0;
            len_cnt  <= '0;
            aes_cnt  <= '0;
        end else if (beat_fire) begin
            if (sop) begin
                pkt_open <= !eop;
                len_cnt  <= '0;
                aes_cnt  <= '0;
            end else begin
                if (is_data && pkt_open) begin
                    if (len_cnt != '1) begin
                        len_cnt <= len_cnt + 1'b1;
                    end
                    if (aes && aes_cnt != '1) begin
                        aes_cnt <= aes_cnt + 1'b1;
                    end
                end
                if (eop) begin
                    pkt_open <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/crypto_req_cred_track.sv
`timescale 1ns/1ps
// Credential tracker. Holds whether a key is loaded and flags data beats
// without a key and AES requests while AES is disabled.
// Assumes a key beat and an SA update beat never coincide (one kind per beat).
module crypto_req_cred_track
    import crypto_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_fire,
    input  beat_kind_e kind,
    input  logic       aes,
    input  logic       cfg_aes_en,
    output logic       key_ok,
    output logic       viol_no_key,
    output logic       viol_aes_off
);

    // Raw credential rule flags.
    always_comb begin
        viol_no_key  = beat_fire && (kind == KIND_DATA) && !key_ok;
        viol_aes_off = beat_fire && aes && !cfg_aes_en;
    end

    // Key presence: loaded by a key beat, dropped by an SA update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_ok <= 1'b0;
        end else if (beat_fire) begin
            if (kind == KIND_KEY) begin
                key_ok <= 1'b1;
            end else if (kind == KIND_SA) begin
                key_ok <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crypto_req_err_capture.sv
`timescale 1ns/1ps
// Error capture. Picks the highest-precedence raw violation, latches the
// first one seen after reset, and strobes it for one cycle.
// Assumes violation bit i corresponds to rank i in the package table.
module crypto_req_err_capture
    import crypto_req_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_VIOL-1:0] viol,
    output logic                err_status,
    output logic [CODE_W-1:0]   err_code,
    output logic                err_irq
);

    logic [CODE_W-1:0] pick_code;

    // Precedence encoder: the lowest rank set wins.
    always_comb begin
        pick_code = '0;
        for (int i = NUM_VIOL - 1; i >= 0; i--) begin
            if (viol[i]) begin
                pick_code = CODE_BY_RANK[i];
            end
        end
    end

    // First-error capture with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_status <= 1'b0;
            err_code   <= '0;
            err_irq    <= 1'b0;
        end else if (!err_irq && (|viol)) begin
            err_status <= 1'b1;
            err_code   <= pick_code;
            err_irq    <= 1'b1;
        end else begin
            err_status <= 1'b0;
        end
    end

endmodule

// File: rtl/crypto_req_checker.sv
`timescale 1ns/1ps
// Crypto stream request protocol checker (top). Observes a request stream
// and reports the first ordering violation with a fixed code.
// Assumes the sideband is meaningful only when valid and ready are both high.
module crypto_req_checker
    import crypto_req_pkg::*;
#(
    parameter int unsigned MAX_PKT_BEATS = 4096,
    parameter int unsigned CTR_W         = 32,
    parameter logic [CTR_W-1:0] CTR_LIMIT = {{(CTR_W-1){1'b1}}, 1'b0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_aes_en,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_aes,
    input  logic              req_sob,
    input  logic              req_eob,
    input  logic              req_sop,
    input  logic              req_eop,
    output logic              err_status,
    output logic [CODE_W-1:0] err_code,
    output logic              err_irq
);

    logic                beat_fire;
    beat_kind_e          kind;
    logic                blk_open;
    logic                pkt_open;
    logic                key_ok;
    logic [NUM_VIOL-1:0] viol;

    // Handshake and kind decode.
    always_comb begin
        beat_fire = req_valid && req_ready;
        kind      = beat_kind_e'(req_kind);
    end

    crypto_req_block_track u_blk (
        .clk             (clk),
        .rst_n           (rst_n),
        .beat_fire       (beat_fire),
        .sob             (req_sob),
        .eob             (req_eob),
        .blk_open        (blk_open),
        .viol_no_sob     (viol[RANK_NO_SOB]),
        .viol_eob_orphan (viol[RANK_EOB_ORPHAN])
    );

    crypto_req_packet_track #(
        .MAX_PKT_BEATS (MAX_PKT_BEATS),
        .CTR_W         (CTR_W),
        .CTR_LIMIT     (CTR_LIMIT)
    ) u_pkt (
        .clk           (clk),
        .rst_n         (rst_n),
        .beat_fire     (beat_fire),
        .kind          (kind),
        .aes           (req_aes),
        .sop           (req_sop),
        .eop           (req_eop),
        .pkt_open      (pkt_open),
        .viol_no_iv    (viol[RANK_NO_IV]),
        .viol_ctr_wrap (viol[RANK_CTR_WRAP]),
        .viol_no_eop   (viol[RANK_NO_EOP])
    );

    crypto_req_cred_track u_cred (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_fire    (beat_fire),
        .kind         (kind),
        .aes          (req_aes),
        .cfg_aes_en   (cfg_aes_en),
        .key_ok       (key_ok),
        .viol_no_key  (viol[RANK_NO_KEY]),
        .viol_aes_off (viol[RANK_AES_OFF])
    );

    crypto_req_err_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .viol       (viol),
        .err_status (err_status),
        .err_code   (err_code),
        .err_irq    (err_irq)
    );

endmodule

// File: rtl/crypto_req_checker_sva.sv
`timescale 1ns/1ps
// Assertion checker for crypto_req_checker, attached by bind below.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module crypto_req_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       beat_fire,
    input logic       cfg_aes_en,
    input logic       req_aes,
    input logic       req_sob,
    input logic       req_eob,
    input logic       blk_open,
    input logic       err_status,
    input logic [7:0] err_code,
    input logic       err_irq
);

    AST_AES_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && req_aes && !cfg_aes_en && !err_irq) |=> (err_status && err_code == 8'h13)); // R2

    AST_EOB_ORPHAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && req_eob && !req_sob && !blk_open && !(req_aes && !cfg_aes_en) && !err_irq)
        |=> (err_status && err_code == 8'h03)); // R3

    AST_STATUS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        err_status |=> !err_status); // R10

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> (err_irq && $stable(err_code))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_fire && !err_irq) |=> !err_status); // R11

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        err_status |-> (err_code == 8'h13 || err_code == 8'h03 || err_code == 8'h02 ||
                        err_code == 8'h17 || err_code == 8'h19 || err_code == 8'h07 ||
                        err_code == 8'h1B)); // R9

endmodule

bind crypto_req_checker crypto_req_checker_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_fire  (beat_fire),
    .cfg_aes_en (cfg_aes_en),
    .req_aes    (req_aes),
    .req_sob    (req_sob),
    .req_eob    (req_eob),
    .blk_open   (blk_open),
    .err_status (err_status),
    .err_code   (err_code),
    .err_irq    (err_irq)
);

// File: tb/crypto_req_checker_tb_top.sv
`timescale 1ns/1ps
module crypto_req_checker_tb_top;

    localparam int MAXB = 12;
    localparam int LIM  = 5;
    localparam logic [1:0] K_DATA = 2'd0, K_KEY = 2'd1, K_IV = 2'd2, K_SA = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_aes_en = 1'b1;
    logic       req_valid = 1'b0, req_ready = 1'b1;
    logic [1:0] req_kind = 2'd0;
    logic       req_aes = 1'b0, req_sob = 1'b0, req_eob = 1'b0, req_sop = 1'b0, req_eop = 1'b0;
    logic       err_status, err_irq;
    logic [7:0] err_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    crypto_req_checker #(.MAX_PKT_BEATS(MAXB), .CTR_W(4), .CTR_LIMIT(4'd5)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_aes_en(cfg_aes_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_aes(req_aes), .req_sob(req_sob), .req_eob(req_eob),
        .req_sop(req_sop), .req_eop(req_eop),
        .err_status(err_status), .err_code(err_code), .err_irq(err_irq)
    );

    // Behavioural reference model
    bit m_blk, m_pkt, m_key, m_seen, m_pulse;
    int m_len, m_ctr;
    logic [7:0] m_code;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_blk = 0; m_pkt = 0; m_key = 0; m_seen = 0; m_pulse = 0;
            m_len = 0; m_ctr = 0; m_code = 8'h00;
        end else begin
            logic [7:0] c;
            bit data;
            c = 8'h00;
            m_pulse = 0;
            data = (req_kind == K_DATA);
            if (req_valid && req_ready) begin
                if (req_aes && !cfg_aes_en) c = 8'h13;
                else if (req_eob && !req_sob && !m_blk) c = 8'h03;
                else if (!req_sob && !m_blk) c = 8'h02;
                else if (data && !m_key) c = 8'h17;
                else if (req_sop ? (req_kind != K_IV) : (data && !m_pkt)) c = 8'h19;
                else if (data && req_aes && m_pkt && m_ctr >= LIM) c = 8'h07;
                else if (data && m_pkt && m_len + 1 >= MAXB && !req_eop) c = 8'h1B;
                if (c != 8'h00 && !m_seen) begin
                    m_seen = 1; m_code = c; m_pulse = 1;
                end
                if (req_eob) m_blk = 0; else if (req_sob) m_blk = 1;
                if (req_kind == K_KEY) m_key = 1; else if (req_kind == K_SA) m_key = 0;
                if (req_sop) begin
                    m_len = 0; m_ctr = 0; m_pkt = !req_eop;
                end else begin
                    if (data && m_pkt) begin
                        m_len++;
                        if (req_aes) m_ctr++;
                    end
                    if (req_eop) m_pkt = 0;
                end
            end
        end
    end

    function automatic string tag_of(logic [7:0] c);
        case (c)
            8'h13: return "R2"; 8'h03: return "R3"; 8'h02: return "R4";
            8'h17: return "R5"; 8'h19: return "R6"; 8'h1B: return "R7";
            8'h07: return "R8"; default: return "R10";
        endcase
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (err_status !== m_pulse || err_irq !== m_seen || err_code !== m_code) begin
                errors++;
                $display("FAIL %s model: status/irq/code act %b/%b/%h exp %b/%b/%h",
                         tag_of(m_code), err_status, err_irq, err_code, m_pulse, m_seen, m_code);
            end
        end
    end

    task automatic check_now(input logic st, input logic irq, input logic [7:0] code, input string tag);
        checks++;
        if (err_status !== st || err_irq !== irq || err_code !== code) begin
            errors++;
            $display("FAIL %s: status/irq/code act %b/%b/%h exp %b/%b/%h",
                     tag, err_status, err_irq, err_code, st, irq, code);
        end
    endtask

    task automatic beat(input logic [1:0] k, input logic a, input logic sb, input logic eb,
                        input logic sp, input logic ep);
        @(negedge clk);
        req_valid = 1; req_ready = 1; req_kind = k; req_aes = a;
        req_sob = sb; req_eob = eb; req_sop = sp; req_eop = ep;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_sob = 0; req_eob = 0; req_sop = 0; req_eop = 0; req_aes = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 0; rst_n = 0; cfg_aes_en = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check_now(0, 0, 8'h00, "R1 reset");

        // R1 legal sequence
        beat(K_KEY, 0, 1, 0, 0, 0);
        beat(K_IV, 0, 0, 0, 1, 0);
        beat(K_DATA, 0, 0, 0, 0, 0);
        beat(K_DATA, 1, 0, 0, 0, 0);
        beat(K_DATA, 0, 0, 1, 0, 1);
        idle();
        check_now(0, 0, 8'h00, "R1 legal");

        // R11 illegal beat without ready is ignored
        do_reset();
        @(negedge clk);
        req_valid = 1; req_ready = 0; req_kind = K_DATA; req_eob = 1;
        @(negedge clk);
        @(negedge clk);
        check_now(0, 0, 8'h00, "R11 no handshake");
        req_ready = 1; req_valid = 0; req_eob = 0;

        // R4 then R10 second error ignored
        do_reset();
        beat(K_DATA, 0, 0, 0, 0, 0);
        idle();
        check_now(1, 1, 8'h02, "R4");
        beat(K_KEY, 1, 0, 1, 0, 0);
        idle();
        check_now(0, 1, 8'h02, "R10 later error ignored");
        @(negedge clk);
        check_now(0, 1, 8'h02, "R10 held");

        // R3 orphan end-of-block outranks missing start (R9)
        do_reset();
        beat(K_KEY, 0, 0, 1, 0, 0);
        idle();
        check_now(1, 1, 8'h03, "R3");

        // R2 AES disabled
        do_reset();
        cfg_aes_en = 0;
        beat(K_KEY, 1, 1, 0, 0, 0);
        idle();
        check_now(1, 1, 8'h13, "R2");

        // R9 AES disabled outranks orphan eob and no key
        do_reset();
        cfg_aes_en = 0;
        beat(K_DATA, 1, 0, 1, 0, 0);
        idle();
        check_now(1, 1, 8'h13, "R9");

        // R5 no key
        do_reset();
        beat(K_IV, 0, 1, 0, 1, 0);
        beat(K_DATA, 0, 0, 0, 0, 0);
        idle();
        check_now(1, 1, 8'h17, "R5 no key");

        // R5 SA update drops key
        do_reset();
        beat(K_KEY, 0, 1, 0, 0, 0);
        beat(K_SA, 0, 0, 0, 0, 0);
        beat(K_IV, 0, 0, 0, 1, 0);
        idle();
        check_now(0, 0, 8'h00, "R5 before data");
        beat(K_DATA, 0, 0, 0, 0, 0);
        idle();
        check_now(1, 1, 8'h17, "R5 after SA");

        // R6 data outside packet
        do_reset();
        beat(K_KEY, 0, 1, 0, 0, 0);
        beat(K_DATA, 0, 0, 0, 0, 0);
        idle();
        check_now(1, 1, 8'h19, "R6 no packet");

        // R6 start-of-packet on non-IV beat
        do_reset();
        beat(K_KEY, 0, 1, 0, 0, 0);
        beat(K_DATA, 0, 0, 0, 1, 0);
        idle();
        check_now(1, 1, 8'h19, "R6 sop not IV");

        // R8 count restarts at sop, then overflow
        do_reset();
        beat(K_KEY, 0, 1, 0, 0, 0);
        beat(K_IV, 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) beat(K_DATA, 1, 0, 0, 0, 0);
        beat(K_IV, 0, 0, 0, 1, 0);
        for (int i = 0; i < LIM; i++) beat(K_DATA, 1, 0, 0, 0, 0);
        idle();
        check_now(0, 0, 8'h00, "R8 at limit");
        beat(K_DATA, 1, 0, 0, 0, 0);
        idle();
        check_now(1, 1, 8'h07, "R8 overflow");

        // R7 last beat with eop is legal; without eop errors
        do_reset();
        beat(K_KEY, 0, 1, 0, 0, 0);
        beat(K_IV, 0, 0, 0, 1, 0);
        for (int i = 0; i < MAXB - 1; i++) beat(K_DATA, 0, 0, 0, 0, 0);
        beat(K_DATA, 0, 0, 0, 0, 1);
        idle();
        check_now(0, 0, 8'h00, "R7 eop at limit");
        beat(K_IV, 0, 0, 0, 1, 0);
        for (int i = 0; i < MAXB - 1; i++) beat(K_DATA, 0, 0, 0, 0, 0);
        idle();
        check_now(0, 0, 8'h00, "R7 below limit");
        beat(K_DATA, 0, 0, 0, 0, 0);
        idle();
        check_now(1, 1, 8'h1B, "R7 no eop");

        do_reset();
        @(negedge clk);
        check_now(0, 0, 8'h00, "R10 reset clears");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule